// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers a set of interrupt sources (32 by default) into a single summary request for a parent interrupt controller. Every source goes through a two-flop synchronizer. The block is then built in one of two variants, chosen at compile time. In the latched variant, a rising edge on a source sets a sticky pending bit, and software acknowledges it by writing a one to an acknowledge register. In the level variant, the pending word is simply the synchronized live input, so no acknowledge register exists.

Each source has a mask bit. There is no read-write mask register. Software changes the mask through two write-only strobe registers, one that sets mask bits and one that clears them, and reads the result back from a read-only mask view. The summary line is high while any source is both pending and unmasked.

Software reaches the registers over a simple bus. A request is a single-cycle valid pulse with a write flag, a byte address and write data. Read data appears one cycle later. The two variants use different register offsets.

Top module: `irq_l2_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1, every pending bit reads 0 and `irq_o` is 0.
- R2: A write to the mask-set register (latched 0x10, level 0x08) sets each mask bit whose data bit is 1 and leaves bits written 0 unchanged. A single write of all ones masks every source.
- R3: A write to the mask-clear register (latched 0x14, level 0x0C) clears each mask bit whose data bit is 1 and leaves bits written 0 unchanged.
- R4: A read of the mask-view register (latched 0x0C, level 0x04) returns the current mask, where 1 means masked. A read of the pending register (0x00 in both variants) returns the pending word.
- R5: In the latched variant, a rising edge on a synchronized source sets its pending bit whether or not the source is masked. The bit stays set after the input falls. A source that rises just before clock edge N shows as pending from edge N+2 onward.
- R6: In the latched variant, writing a 1 to a bit of the acknowledge register (0x08) clears that pending bit, and bits written 0 have no effect. If a new edge and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R7: In the level variant, the pending word follows the synchronized inputs from edge N+1 onward, and offset 0x08 acts as mask-set rather than acknowledge.
- R8: `irq_o` is 1 exactly when some source has pending 1 and mask 0.
- R9: Writes to the pending register, to the mask-view register or to unmapped offsets change nothing. Reads of unmapped offsets and of write-only registers return zero.
- R10: Read data for a read request is presented on `bus_rdata_o` in the cycle after the request and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source inputs |
| bus_valid_i | input | 1 | Register request valid, one cycle per request |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rdata_o | output | NUM_SRC | Read data, one cycle after a read request |
| irq_o | output | 1 | Summary interrupt request to the parent controller |

## Verification
The hardest case to reach from the ports is a new rising edge that arrives in exactly the cycle in which an acknowledge write for the same bit is captured. The bench raises the source at a falling edge, waits two cycles for the synchronizer, and then issues the acknowledge so that it lands on the clock edge that detects the new edge. It then reads the pending bit back. Sync latency is checked the same way, by sampling `irq_o` of both variants after two and three edges. Random source, mask and acknowledge traffic runs against a bench model of the pending and mask words.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;
    // Register offsets (bytes); pending is common to both variants
    localparam int OFF_PEND      = 'h00;
    localparam int LAT_OFF_ACK   = 'h08;
    localparam int LAT_OFF_MVIEW = 'h0C;
    localparam int LAT_OFF_MSET  = 'h10;
    localparam int LAT_OFF_MCLR  = 'h14;
    localparam int LVL_OFF_MVIEW = 'h04;
    localparam int LVL_OFF_MSET  = 'h08;
    localparam int LVL_OFF_MCLR  = 'h0C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ACK,
        SEL_MVIEW,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;

    function automatic int off_mview(input bit latched);
        return latched ? LAT_OFF_MVIEW : LVL_OFF_MVIEW;
    endfunction

    function automatic int off_mset(input bit latched);
        return latched ? LAT_OFF_MSET : LVL_OFF_MSET;
    endfunction

    function automatic int off_mclr(input bit latched);
        return latched ? LAT_OFF_MCLR : LVL_OFF_MCLR;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int W       = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] pend_o
);
    generate
        if (LATCHED) begin : g_latched
            typedef struct packed {
                logic [W-1:0] prev;
                logic [W-1:0] pend;
            } cap_t;

            cap_t cap_d, cap_q;

            always_comb begin
                cap_d.prev = lvl_i;
                // acknowledge first, then a fresh edge sets: the edge wins
                cap_d.pend = (cap_q.pend & ~ack_i) | (lvl_i & ~cap_q.prev);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= cap_d;
            end

            assign pend_o = cap_q.pend;
        end else begin : g_level
            logic unused_ack;
            assign unused_ack = ^ack_i;
            assign pend_o     = lvl_i;
        end
    endgenerate
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_l2_pkg::*;
#(
    parameter int W       = 32,
    parameter int ADDR_W  = 8,
    parameter bit LATCHED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [W-1:0]      bus_wdata_i,
    input  logic [W-1:0]      pend_i,
    output logic [W-1:0]      mask_o,
    output logic [W-1:0]      ack_o,
    output logic [W-1:0]      rdata_o
);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(LAT_OFF_ACK);
    localparam logic [ADDR_W-1:0] A_MVIEW = ADDR_W'(off_mview(LATCHED));
    localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(off_mset(LATCHED));
    localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(off_mclr(LATCHED));

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] rdata;
    } rf_t;

    rf_t      rf_d, rf_q;
    reg_sel_e sel;
    logic     wr_en, rd_en;

    always_comb begin
        sel = SEL_NONE;
        if (bus_addr_i == A_PEND)                 sel = SEL_PEND;
        else if (bus_addr_i == A_MVIEW)           sel = SEL_MVIEW;
        else if (bus_addr_i == A_MSET)            sel = SEL_MSET;
        else if (bus_addr_i == A_MCLR)            sel = SEL_MCLR;
        else if (LATCHED && bus_addr_i == A_ACK)  sel = SEL_ACK;
    end

    always_comb begin
        wr_en = bus_valid_i &  bus_write_i;
        rd_en = bus_valid_i & ~bus_write_i;

        rf_d       = rf_q;
        rf_d.rdata = '0;
        ack_o      = '0;

        if (wr_en) begin
            unique case (sel)
                SEL_MSET: rf_d.mask = rf_q.mask |  bus_wdata_i;
                SEL_MCLR: rf_d.mask = rf_q.mask & ~bus_wdata_i;
                SEL_ACK:  ack_o     = bus_wdata_i;
                default:  ;
            endcase
        end

        if (rd_en) begin
            unique case (sel)
                SEL_PEND:  rf_d.rdata = pend_i;
                SEL_MVIEW: rf_d.rdata = rf_q.mask;
                default:   rf_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.mask  <= '1;
            rf_q.rdata <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign mask_o  = rf_q.mask;
    assign rdata_o = rf_q.rdata;
endmodule

// File: rtl/irq_l2_ctrl.sv
module irq_l2_ctrl #(
    parameter int NUM_SRC     = 32,
    parameter int ADDR_W      = 8,
    parameter bit LATCHED     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_valid_i,
    input  logic               bus_write_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] sync_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] ack_w;

    irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (sync_w)
    );

    irq_capture #(.W(NUM_SRC), .LATCHED(LATCHED)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_w),
        .ack_i  (ack_w),
        .pend_o (pend_w)
    );

    irq_regfile #(.W(NUM_SRC), .ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid_i (bus_valid_i),
        .bus_write_i (bus_write_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .pend_i      (pend_w),
        .mask_o      (mask_w),
        .ack_o       (ack_w),
        .rdata_o     (bus_rdata_o)
    );

    // Summary request: any source pending and not masked
    assign irq_o = |(pend_w & ~mask_w);
endmodule

// File: rtl/irq_l2_ctrl_chk.sv
module irq_l2_ctrl_chk
    import irq_l2_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8,
    parameter bit LATCHED = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid_i,
    input logic               bus_write_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [NUM_SRC-1:0] bus_wdata_i,
    input logic [NUM_SRC-1:0] bus_rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_w,
    input logic [NUM_SRC-1:0] mask_w,
    input logic [NUM_SRC-1:0] sync_w
);
    localparam logic [ADDR_W-1:0] C_PEND  = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] C_MVIEW = ADDR_W'(off_mview(LATCHED));
    localparam logic [ADDR_W-1:0] C_MSET  = ADDR_W'(off_mset(LATCHED));
    localparam logic [ADDR_W-1:0] C_MCLR  = ADDR_W'(off_mclr(LATCHED));
    localparam logic [ADDR_W-1:0] C_ACK   = ADDR_W'(LAT_OFF_ACK);

    logic [NUM_SRC-1:0] sync_prev_q;
    logic [NUM_SRC-1:0] rise_c;
    logic wr_set, wr_clr, wr_ack, rd_blank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_prev_q <= '0;
        else        sync_prev_q <= sync_w;
    end

    assign rise_c   = sync_w & ~sync_prev_q;
    assign wr_set   = bus_valid_i && bus_write_i && bus_addr_i == C_MSET;
    assign wr_clr   = bus_valid_i && bus_write_i && bus_addr_i == C_MCLR;
    assign wr_ack   = LATCHED && bus_valid_i && bus_write_i && bus_addr_i == C_ACK;
    assign rd_blank = bus_valid_i && !bus_write_i &&
                      bus_addr_i != C_PEND && bus_addr_i != C_MVIEW;

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_w & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_w & $past(bus_wdata_i)) == '0));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(mask_w));

    p_blank_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_blank |=> (bus_rdata_o == '0));

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid_i && !bus_write_i) |=> (bus_rdata_o == '0));

    p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '1) |-> !irq_o);

    p_none_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w == '0) |-> !irq_o);

    generate
        if (LATCHED) begin : g_lat_props
            p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (rise_c != '0) |=> ((pend_w & $past(rise_c)) == $past(rise_c)));

            p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_ack |=> ((pend_w & $past(pend_w)) == $past(pend_w)));
        end
    endgenerate
endmodule

bind irq_l2_ctrl irq_l2_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .LATCHED (LATCHED)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .pend_w      (pend_w),
    .mask_w      (mask_w),
    .sync_w      (sync_w)
);

// File: tb/irq_l2_ctrl_tb.sv
module irq_l2_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        v_a = 1'b0, v_b = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_mask_a, m_mask_b, m_pend_a;

    always #2 clk = ~clk;

    irq_l2_ctrl #(.LATCHED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_valid_i(v_a),
        .bus_write_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata_a), .irq_o(irq_a));

    irq_l2_ctrl #(.LATCHED(1'b0)) u_dut_lvl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_valid_i(v_b),
        .bus_write_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata_b), .irq_o(irq_b));

    function automatic logic exp_irq(input logic [31:0] p, input logic [31:0] m);
        return |(p & ~m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input bit lvl, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        if (lvl) v_b = 1'b1; else v_a = 1'b1;
        @(negedge clk);
        v_a = 1'b0; v_b = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input bit lvl, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        wr = 1'b0; addr = a;
        if (lvl) v_b = 1'b1; else v_a = 1'b1;
        @(negedge clk);
        v_a = 1'b0; v_b = 1'b0;
        d = lvl ? rdata_b : rdata_a;
    endtask

    task automatic set_src(input logic [31:0] nv);
        @(negedge clk);
        m_pend_a = m_pend_a | (nv & ~src);
        src = nv;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        bus_rd(1'b0, 8'h00, d); check({tag, " R4 pend A"}, d, m_pend_a);
        bus_rd(1'b0, 8'h0C, d); check({tag, " R4 mask A"}, d, m_mask_a);
        bus_rd(1'b1, 8'h00, d); check({tag, " R7 pend B"}, d, src);
        bus_rd(1'b1, 8'h04, d); check({tag, " R4 mask B"}, d, m_mask_b);
        check({tag, " R8 irq A"}, 32'(irq_a), 32'(exp_irq(m_pend_a, m_mask_a)));
        check({tag, " R8 irq B"}, 32'(irq_b), 32'(exp_irq(src, m_mask_b)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        m_mask_a = '1; m_mask_b = '1; m_pend_a = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq A", 32'(irq_a), 0);
        check("R1 irq B", 32'(irq_b), 0);
        check_all("R1");

        // R3 / R2 mask strobes on A
        bus_wr(1'b0, 8'h14, 32'hFFFF_FFFF); m_mask_a = '0;
        bus_rd(1'b0, 8'h0C, d); check("R3 clear all", d, 32'h0);
        bus_wr(1'b0, 8'h10, 32'h0000_00F0); m_mask_a = 32'hF0;
        bus_rd(1'b0, 8'h0C, d); check("R2 partial set", d, 32'hF0);
        bus_wr(1'b0, 8'h10, 32'h0);
        bus_rd(1'b0, 8'h0C, d); check("R2 zero no effect", d, 32'hF0);
        bus_wr(1'b0, 8'h14, 32'h10); m_mask_a = 32'hE0;
        bus_rd(1'b0, 8'h0C, d); check("R3 partial clear", d, 32'hE0);
        bus_wr(1'b0, 8'h10, 32'hFFFF_FFFF); m_mask_a = '1;
        bus_rd(1'b0, 8'h0C, d); check("R2 single-write all ones", d, 32'hFFFF_FFFF);
        bus_wr(1'b0, 8'h14, 32'hFFFF_FFFF); m_mask_a = '0;
        bus_wr(1'b1, 8'h0C, 32'hFFFF_FFFF); m_mask_b = '0;

        // R9 ignored writes, blank reads
        bus_wr(1'b0, 8'h0C, 32'hFFFF_FFFF);
        bus_wr(1'b0, 8'h00, 32'hFFFF_FFFF);
        bus_wr(1'b0, 8'h1C, 32'hFFFF_FFFF);
        bus_wr(1'b1, 8'h04, 32'hFFFF_FFFF);
        bus_rd(1'b0, 8'h0C, d); check("R9 mask A untouched", d, 32'h0);
        bus_rd(1'b0, 8'h00, d); check("R9 pend A untouched", d, 32'h0);
        bus_rd(1'b1, 8'h04, d); check("R9 mask B untouched", d, 32'h0);
        bus_rd(1'b0, 8'h04, d); check("R9 unmapped read", d, 32'h0);
        bus_rd(1'b0, 8'h10, d); check("R9 write-only read", d, 32'h0);
        bus_rd(1'b1, 8'h14, d); check("R9 unmapped read B", d, 32'h0);
        @(negedge clk);
        check("R10 idle rdata", rdata_a, 32'h0);

        // R5 / R7 sync latency seen on irq (all unmasked)
        @(negedge clk);
        src = 32'h1; m_pend_a = 32'h1;
        @(negedge clk);
        check("R5 not yet after 1 edge A", 32'(irq_a), 0);
        check("R7 not yet after 1 edge B", 32'(irq_b), 0);
        @(negedge clk);
        check("R5 not yet after 2 edges A", 32'(irq_a), 0);
        check("R7 level after 2 edges B", 32'(irq_b), 1);
        @(negedge clk);
        check("R5 latched after 3 edges A", 32'(irq_a), 1);

        // R5 masked source still latches; stays after input falls
        bus_wr(1'b0, 8'h10, 32'h8); m_mask_a = 32'h8;
        set_src(32'h9);
        bus_rd(1'b0, 8'h00, d); check("R5 masked edge latches", d, 32'h9);
        set_src(32'h0);
        bus_rd(1'b0, 8'h00, d); check("R5 sticky after fall", d, 32'h9);
        check("R8 irq from unmasked bit", 32'(irq_a), 1);
        check("R7 level follows low", 32'(irq_b), 0);

        // R6 acknowledge
        bus_wr(1'b0, 8'h08, 32'h1); m_pend_a = 32'h8;
        bus_rd(1'b0, 8'h00, d); check("R6 ack clears", d, 32'h8);
        check("R8 only masked pending", 32'(irq_a), 0);
        bus_wr(1'b0, 8'h08, 32'h0);
        bus_rd(1'b0, 8'h00, d); check("R6 zero ack no effect", d, 32'h8);

        // R6 edge and ack of same bit in one cycle: edge wins
        @(negedge clk);
        src = 32'h20;
        @(negedge clk);
        bus_wr(1'b0, 8'h08, 32'h20);
        m_pend_a = 32'h28;
        bus_rd(1'b0, 8'h00, d); check("R6 set wins over ack", d, 32'h28);

        // R7 offset 0x08 on level variant is mask-set
        bus_wr(1'b1, 8'h08, 32'h20); m_mask_b = 32'h20;
        bus_rd(1'b1, 8'h04, d); check("R7 0x08 masks on level", d, 32'h20);
        check("R8 level masked", 32'(irq_b), 0);
        check_all("directed");

        // Random traffic
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] r;
            op = int'($urandom_range(0, 5));
            r  = $urandom() & $urandom();
            case (op)
                0: set_src($urandom());
                1: begin bus_wr(1'b0, 8'h10, r); m_mask_a |= r; end
                2: begin bus_wr(1'b0, 8'h14, r | $urandom()); m_mask_a = m_mask_a & ~(r | wdata); end
                3: begin bus_wr(1'b0, 8'h08, $urandom()); m_pend_a &= ~wdata; end
                4: begin
                    if (r[0]) begin bus_wr(1'b1, 8'h08, r); m_mask_b |= r; end
                    else begin bus_wr(1'b1, 8'h0C, ~r); m_mask_b &= r; end
                end
                default: check_all("random");
            endcase
            @(negedge clk);
            check("R8 random irq A", 32'(irq_a), 32'(exp_irq(m_pend_a, m_mask_a)));
            check("R8 random irq B", 32'(irq_b), 32'(exp_irq(src, m_mask_b)));
        end
        check_all("final");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule